// File: doc/BRIEF.md
# Burst SRAM Access and Byte-Write Controller

This block is the synchronous front end of a common-I/O burst SRAM. On every rising clock edge it samples three active-low chip selects, two active-low address strobes (one meant for a processor, one for a cache controller), an advance input, a burst-order select, the write controls and the address. From these it decides whether the edge starts a read, starts a write, continues a burst or ends the burst. It then writes the selected byte lanes of a small internal array or fetches one word into a registered read port.

The array holds 32-bit words in four 8-bit byte lanes. A two-bit burst counter supplies the low address bits for the later beats of a burst. The counter can step in linear order (wrap-around increment) or interleaved order (XOR with the beat count). The upper address bits come from an address register that is loaded when the access starts. The read-data drive enable is combinational in the output enable and in the write controls, so the bus is released at once when a write shows up.

The pin interface is a fixed-timing synchronous memory port. It has no valid/ready handshake and no back-pressure. The block accepts every edge, and a word read at an edge is held in the read port until the next edge.

Top module: `sram_burst_front`

## Requirements
- R1: An access starts at a rising edge only when `cs1_n`, `cs2_n` and `cs3_n` are all low and at least one of `pstrb_n` or `cstrb_n` is low. When no burst is active and no access starts, nothing is read: `dq_oe` stays low even with `oe_n` low.
- R2: While `cs1_n` is high, `pstrb_n` is ignored. With `cstrb_n` high, an active burst then continues, and `adv_n` low steps it to the next beat.
- R3: An access started by `pstrb_n` ignores the write controls in its start cycle and reads the start address. If the write controls show a write at the next edge (with `adv_n` high), the `wdata` present at that edge is written to the start address.
- R4: An access started by `cstrb_n` (with `pstrb_n` high) writes `wdata` at the start address in the same edge if the write controls show a write. Otherwise it is a read whose word appears on `rdata` after that edge.
- R5: When `pstrb_n` and `cstrb_n` are both low with `cs1_n` low, the processor strobe wins. No write takes place at that edge, whatever the write controls show.
- R6: `gwr_n` low writes all four byte lanes, whatever the values of `bwen_n` and `bsel_n`.
- R7: With `gwr_n` high, the lane mask is `{4{~bwen_n}} & ~bsel_n`. Bit i of the mask selects `wdata[8i+7:8i]`. An all-zero mask is not a write: the beat is a read, and the word stays unchanged.
- R8: `dq_oe` is low in any cycle where the write controls show a write, whatever `oe_n` is. It is also low after any write edge.
- R9: `dq_oe` is high only while `oe_n` is low and a read word is held. A change of `oe_n` affects `dq_oe` with no clock edge.
- R10: Beat n of a burst addresses `{start[5:2], off}`. In linear order (`burst_ilv`=0 at the start edge), `off` = (start[1:0]+n) mod 4. In interleaved order (`burst_ilv`=1), `off` = start[1:0] XOR n. The order is taken at the start edge only. `adv_n` low at a continuing edge moves to the next beat.
- R11: `cstrb_n` low while the chip selects are not all low, or `pstrb_n` low with `cs1_n` low and another select high, ends the burst. `dq_oe` then goes low, and later write controls write nothing until a new access starts.
- R12: While `rst_n` is low, no burst is active and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs1_n | input | 1 | Chip select 1 (also gates the processor strobe), active low |
| cs2_n | input | 1 | Chip select 2, active low |
| cs3_n | input | 1 | Chip select 3, active low |
| pstrb_n | input | 1 | Processor address strobe, active low |
| cstrb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| burst_ilv | input | 1 | Burst order at start: 0 linear, 1 interleaved |
| gwr_n | input | 1 | Global write, all lanes, active low |
| bwen_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | 4 | Per-lane byte select, active low |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 32 | Registered read word |
| dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The assertions check the following on every cycle:
- The bus drive stays off under `oe_n` high and under any write indication.
- A global write always covers all four lanes.
- A processor-strobe start never writes.
- A burst never becomes active without qualified selects and a strobe.
- A processor strobe with `cs1_n` high never ends a burst.

Only the bench's scenarios can show that data lands at the right address and lane. This covers linear and interleaved beat order, the deferred write of a processor-strobe access, partial byte masks, and the fact that reads after a deselect return the untouched contents.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  // What one sampled clock edge does to the access state.
  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_START_P,
    ACC_START_C,
    ACC_CONT,
    ACC_DESEL
  } acc_kind_e;

endpackage

// File: rtl/sfc_burst_counter.sv
module sfc_burst_counter #(
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             mode_in,
  input  logic [OFF_W-1:0] start_off,
  input  logic             step,
  output logic [OFF_W-1:0] cur_off,
  output logic [OFF_W-1:0] next_off
);

  localparam logic [OFF_W-1:0] ONE = {{(OFF_W-1){1'b0}}, 1'b1};

  logic [OFF_W-1:0] start_q;
  logic [OFF_W-1:0] cnt_q;
  logic [OFF_W-1:0] cnt_nx;
  logic             ilv_q;

  function automatic logic [OFF_W-1:0] beat_off(input logic ilv,
                                                input logic [OFF_W-1:0] s,
                                                input logic [OFF_W-1:0] c);
    return ilv ? (s ^ c) : (s + c);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      cnt_q   <= '0;
      ilv_q   <= 1'b0;
    end else if (load) begin
      start_q <= start_off;
      cnt_q   <= '0;
      ilv_q   <= mode_in;
    end else if (step) begin
      cnt_q   <= cnt_nx;
    end
  end

  assign cnt_nx   = cnt_q + ONE;
  assign cur_off  = beat_off(ilv_q, start_q, cnt_q);
  assign next_off = beat_off(ilv_q, start_q, cnt_nx);

endmodule

// File: rtl/sfc_access_decode.sv
module sfc_access_decode
  import sfc_pkg::*;
(
  input  logic      cs1_n,
  input  logic      cs2_n,
  input  logic      cs3_n,
  input  logic      pstrb_n,
  input  logic      cstrb_n,
  input  logic      burst_active,
  output acc_kind_e kind
);

  logic sel_all;

  assign sel_all = ~cs1_n & ~cs2_n & ~cs3_n;

  always_comb begin
    if (!pstrb_n && !cs1_n) begin
      // Processor strobe counts only under select 1; it beats the controller strobe.
      kind = sel_all ? ACC_START_P : ACC_DESEL;
    end else if (!cstrb_n) begin
      kind = sel_all ? ACC_START_C : ACC_DESEL;
    end else if (burst_active) begin
      kind = ACC_CONT;
    end else begin
      kind = ACC_IDLE;
    end
  end

endmodule

// File: rtl/sfc_lane_array.sv
module sfc_lane_array #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int AW     = 6,
  parameter int DEPTH  = 64
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic                    rd_en,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (wr_lanes[g]) begin
        mem[addr] <= wdata[g*LANE_W +: LANE_W];
      end
      if (rd_en) begin
        lane_q <= mem[addr];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = lane_q;
  end

endmodule

// File: rtl/sram_burst_front.sv
module sram_burst_front
  import sfc_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int LANES     = 4,
  parameter int LANE_W    = 8,
  parameter int BURST_LEN = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs1_n,
  input  logic                    cs2_n,
  input  logic                    cs3_n,
  input  logic                    pstrb_n,
  input  logic                    cstrb_n,
  input  logic                    adv_n,
  input  logic                    burst_ilv,
  input  logic                    gwr_n,
  input  logic                    bwen_n,
  input  logic [LANES-1:0]        bsel_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    dq_oe
);

  localparam int OFF_W = $clog2(BURST_LEN);
  localparam int HI_W  = ADDR_W - OFF_W;
  localparam int DEPTH = 1 << ADDR_W;

  acc_kind_e          kind;
  logic               burst_active;
  logic               rd_valid;
  logic [HI_W-1:0]    base_hi_q;
  logic [LANES-1:0]   mask_raw;
  logic               wr_req;
  logic [LANES-1:0]   wr_lanes;
  logic               rd_en;
  logic               cnt_load;
  logic               cnt_step;
  logic [OFF_W-1:0]   cur_off;
  logic [OFF_W-1:0]   next_off;
  logic [ADDR_W-1:0]  acc_addr;

  sfc_access_decode u_decode (
    .cs1_n        (cs1_n),
    .cs2_n        (cs2_n),
    .cs3_n        (cs3_n),
    .pstrb_n      (pstrb_n),
    .cstrb_n      (cstrb_n),
    .burst_active (burst_active),
    .kind         (kind)
  );

  sfc_burst_counter #(.OFF_W(OFF_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cnt_load),
    .mode_in   (burst_ilv),
    .start_off (addr[OFF_W-1:0]),
    .step      (cnt_step),
    .cur_off   (cur_off),
    .next_off  (next_off)
  );

  // Global write covers every lane; otherwise the byte enable gates the selects.
  assign mask_raw = {LANES{~gwr_n}} | ({LANES{~bwen_n}} & ~bsel_n);
  assign wr_req   = |mask_raw;

  always_comb begin
    wr_lanes = '0;
    rd_en    = 1'b0;
    cnt_load = 1'b0;
    cnt_step = 1'b0;
    acc_addr = addr;
    unique case (kind)
      ACC_START_P: begin
        cnt_load = 1'b1;
        rd_en    = 1'b1;
      end
      ACC_START_C: begin
        cnt_load = 1'b1;
        if (wr_req) wr_lanes = mask_raw;
        else        rd_en    = 1'b1;
      end
      ACC_CONT: begin
        cnt_step = ~adv_n;
        acc_addr = {base_hi_q, (adv_n ? cur_off : next_off)};
        if (wr_req) wr_lanes = mask_raw;
        else        rd_en    = 1'b1;
      end
      default: begin
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_active <= 1'b0;
      rd_valid     <= 1'b0;
      base_hi_q    <= '0;
    end else begin
      rd_valid <= rd_en;
      if (kind == ACC_START_P || kind == ACC_START_C) begin
        burst_active <= 1'b1;
        base_hi_q    <= addr[ADDR_W-1:OFF_W];
      end else if (kind == ACC_DESEL) begin
        burst_active <= 1'b0;
      end
    end
  end

  sfc_lane_array #(
    .LANES  (LANES),
    .LANE_W (LANE_W),
    .AW     (ADDR_W),
    .DEPTH  (DEPTH)
  ) u_array (
    .clk      (clk),
    .wr_lanes (wr_lanes),
    .rd_en    (rd_en),
    .addr     (acc_addr),
    .wdata    (wdata),
    .rdata    (rdata)
  );

  // Output enable and write detection act without waiting for a clock edge.
  assign dq_oe = rd_valid & ~oe_n & ~wr_req;

endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs1_n,
  input logic             cs2_n,
  input logic             cs3_n,
  input logic             pstrb_n,
  input logic             cstrb_n,
  input logic             gwr_n,
  input logic             bwen_n,
  input logic [LANES-1:0] bsel_n,
  input logic             oe_n,
  input logic             dq_oe,
  input logic             burst_active,
  input logic [LANES-1:0] wr_lanes
);

  assert_start_needs_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_active && !(!cs1_n && !cs2_n && !cs3_n && (!pstrb_n || !cstrb_n)))
      |=> !burst_active);

  assert_pstrb_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && cs1_n && cstrb_n) |=> burst_active);

  // Covers R3 too: the start cycle of a processor-strobe access writes nothing.
  assert_p_start_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pstrb_n && !cs1_n) |-> (wr_lanes == '0));

  assert_global_all_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!gwr_n && (wr_lanes != '0)) |-> (&wr_lanes));

  assert_write_releases_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!gwr_n || (!bwen_n && !(&bsel_n))) |-> !dq_oe);

  assert_oe_gates_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R12: assert (!dq_oe && !burst_active);
    end
  end

endmodule

bind sram_burst_front sfc_checker #(.LANES(LANES)) u_sfc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs1_n        (cs1_n),
  .cs2_n        (cs2_n),
  .cs3_n        (cs3_n),
  .pstrb_n      (pstrb_n),
  .cstrb_n      (cstrb_n),
  .gwr_n        (gwr_n),
  .bwen_n       (bwen_n),
  .bsel_n       (bsel_n),
  .oe_n         (oe_n),
  .dq_oe        (dq_oe),
  .burst_active (burst_active),
  .wr_lanes     (wr_lanes)
);

// File: tb/test_sram_burst_front.sv
module test_sram_burst_front;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs1_n, cs2_n, cs3_n, pstrb_n, cstrb_n, adv_n, burst_ilv;
  logic        gwr_n, bwen_n, oe_n;
  logic [3:0]  bsel_n;
  logic [5:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        dq_oe;

  logic [31:0] model_mem [64];
  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_burst_front i_sram_burst_front (
    .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2_n(cs2_n), .cs3_n(cs3_n),
    .pstrb_n(pstrb_n), .cstrb_n(cstrb_n), .adv_n(adv_n), .burst_ilv(burst_ilv),
    .gwr_n(gwr_n), .bwen_n(bwen_n), .bsel_n(bsel_n), .addr(addr),
    .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .dq_oe(dq_oe)
  );

  task automatic cyc();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic idle_in();
    cs1_n = 1; cs2_n = 1; cs3_n = 1; pstrb_n = 1; cstrb_n = 1; adv_n = 1;
    gwr_n = 1; bwen_n = 1; bsel_n = 4'hF; wdata = '0; oe_n = 0;
  endtask

  task automatic sel_on();
    cs1_n = 0; cs2_n = 0; cs3_n = 0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int a);
    return 32'h5A000000 ^ (32'(a) * 32'h01030507);
  endfunction

  task automatic single_read(input int a, input string req);
    idle_in(); sel_on(); cstrb_n = 0; addr = 6'(a);
    cyc();
    check(req, rdata, model_mem[a]);
    idle_in();
  endtask

  // R12: reset quiet
  task automatic t_reset();
    idle_in(); addr = 0; burst_ilv = 0; rst_n = 0;
    repeat (3) cyc();
    check("R12 dq_oe in reset", 32'(dq_oe), 32'd0);
    rst_n = 1;
    cyc();
    check("R1 no access after reset", 32'(dq_oe), 32'd0);
  endtask

  // R4/R10: fill every word with controller-strobe linear write bursts
  task automatic t_fill();
    for (int b = 0; b < 16; b++) begin
      int s = b % 4;
      idle_in(); sel_on(); cstrb_n = 0; gwr_n = 0; burst_ilv = 0;
      addr = 6'(b*4 + s); wdata = pat(b*4 + s);
      cyc();
      model_mem[b*4 + s] = pat(b*4 + s);
      cstrb_n = 1; adv_n = 0;
      for (int n = 1; n < 4; n++) begin
        int a = b*4 + ((s + n) % 4);
        wdata = pat(a);
        cyc();
        model_mem[a] = pat(a);
      end
      idle_in(); cyc();
    end
  endtask

  // R10/R9/R4: processor-strobe read burst in either order
  task automatic t_read_burst(input bit ilv, input int a0);
    int s = a0 % 4;
    int hi = a0 - s;
    idle_in(); sel_on(); pstrb_n = 0; burst_ilv = ilv; addr = 6'(a0);
    cyc();
    check("R10 beat0", rdata, model_mem[a0]);
    check("R9 drive on read", 32'(dq_oe), 32'd1);
    pstrb_n = 1; adv_n = 0; burst_ilv = ~ilv;
    for (int n = 1; n < 4; n++) begin
      int a = hi + (ilv ? (s ^ n) : ((s + n) % 4));
      cyc();
      check(ilv ? "R10 interleaved beat" : "R10 linear beat", rdata, model_mem[a]);
    end
    oe_n = 1; #1;
    check("R9 async oe off", 32'(dq_oe), 32'd0);
    oe_n = 0; #1;
    check("R9 async oe on", 32'(dq_oe), 32'd1);
    idle_in();
  endtask

  // R3/R8: deferred write of a processor-strobe access
  task automatic t_p_write();
    idle_in(); sel_on(); pstrb_n = 0; gwr_n = 0; wdata = 32'hDEAD0001; addr = 6'd9;
    cyc();
    check("R3 start reads, ignores write", rdata, model_mem[9]);
    pstrb_n = 1; adv_n = 1; gwr_n = 0; wdata = 32'h13572468; #1;
    check("R8 bus released on write", 32'(dq_oe), 32'd0);
    cyc();
    model_mem[9] = 32'h13572468;
    gwr_n = 1; #1;
    check("R8 no drive after write edge", 32'(dq_oe), 32'd0);
    idle_in(); cyc();
    single_read(9, "R3 deferred write landed");
    cyc();
  endtask

  // R7/R6: partial byte writes, empty mask, global override
  task automatic t_byte();
    logic [31:0] w = 32'hAABBCCDD;
    idle_in(); sel_on(); cstrb_n = 0; bwen_n = 0; bsel_n = 4'b1010; burst_ilv = 0;
    addr = 6'd20; wdata = w;
    cyc();
    model_mem[20] = (model_mem[20] & 32'hFF00FF00) | (w & 32'h00FF00FF);
    cstrb_n = 1; adv_n = 0; bwen_n = 1; bsel_n = 4'b0000; wdata = 32'h0BAD0BAD;
    cyc();
    check("R7 empty mask reads", rdata, model_mem[21]);
    gwr_n = 0; bwen_n = 1; bsel_n = 4'hF; wdata = 32'h600DF00D;
    cyc();
    model_mem[22] = 32'h600DF00D;
    idle_in(); cyc();
    single_read(20, "R7 lanes 0 and 2 only"); cyc();
    single_read(21, "R7 no write on empty mask"); cyc();
    single_read(22, "R6 global write all lanes"); cyc();
  endtask

  // R5: both strobes low, processor wins
  task automatic t_priority();
    idle_in(); sel_on(); pstrb_n = 0; cstrb_n = 0; gwr_n = 0; wdata = 32'hBADBAD00; addr = 6'd30;
    cyc();
    check("R5 read on double strobe", rdata, model_mem[30]);
    idle_in(); cyc();
    single_read(30, "R5 no write on double strobe"); cyc();
  endtask

  // R2: processor strobe ignored with select 1 high
  task automatic t_pstrb_ignored();
    idle_in(); sel_on(); cstrb_n = 0; burst_ilv = 0; addr = 6'd40;
    cyc();
    check("R4 controller read", rdata, model_mem[40]);
    cs1_n = 1; cstrb_n = 1; pstrb_n = 0; adv_n = 0; addr = 6'd3;
    cyc();
    check("R2 burst continued", rdata, model_mem[41]);
    idle_in(); cyc();
  endtask

  // R11/R1: deselect ends burst; later write controls do nothing
  task automatic t_deselect();
    idle_in(); sel_on(); cstrb_n = 0; addr = 6'd44;
    cyc();
    check("R4 read before deselect", rdata, model_mem[44]);
    cs2_n = 1; cstrb_n = 0;
    cyc();
    check("R11 drive off after deselect", 32'(dq_oe), 32'd0);
    sel_on(); cstrb_n = 1; gwr_n = 0; adv_n = 0; wdata = 32'hFFFF0000;
    cyc();
    gwr_n = 1; adv_n = 1;
    cyc();
    check("R1 no access without strobe", 32'(dq_oe), 32'd0);
    cs3_n = 1; pstrb_n = 0;
    cyc();
    check("R1 no access with select 3 high", 32'(dq_oe), 32'd0);
    idle_in(); cyc();
    single_read(44, "R11 word 44 untouched"); cyc();
    single_read(45, "R11 word 45 untouched"); cyc();
  endtask

  initial begin
    t_reset();
    t_fill();
    t_read_burst(1'b0, 14);
    t_read_burst(1'b1, 33);
    t_read_burst(1'b1, 50);
    t_p_write();
    t_byte();
    t_priority();
    t_pstrb_ignored();
    t_deselect();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule